// File: doc/BRIEF.md
# Tiled Matrix Product Accumulator

This block turns a fixed-size matrix-vector engine, which only handles square tiles of `TILE` × `TILE` complex elements, into a full square matrix multiplier for sizes `TILE` · 2^k. It walks three tile indices: output row tile, output column tile, and the shared inner-dimension tile, which changes fastest. For each step it issues one A tile and one B tile request. It then takes the engine's partial product for that tile pair one element per accepted strobe and folds it into an output matrix held in an internal buffer.

Each output tile is built up by read-modify-write. The first inner tile overwrites whatever the buffer held. Every later inner tile reads the stored partial sum, adds the new contribution at full accumulator width and writes the sum back. If a result targets the address that is being written in the same cycle, the pending sum is forwarded. When the last sum is written, a done flag rises. The finished matrix is then read out through an address port, with each component clamped to 16 bits.

Top module: `gemm_tile_acc`

## Requirements
- R1: `dimLog` selects the matrix size N = TILE · 2^dimLog. Values above log2(MAX_TILES) are treated as log2(MAX_TILES).
- R2: A `start` pulse while idle raises `aReq` and `bReq` in the same cycle, with all tile indices zero. A request names the A tile (row i, inner k) and the B tile (inner k, column j).
- R3: Tile pairs are visited with k innermost, then j, then i. The next request is asserted combinationally in the cycle that accepts the final element of the current tile. No request follows the final tile.
- R4: Results are accepted only between a request and the final element of the run. Each tile delivers TILE·TILE elements in row-major order within the tile. `resData` packs {imaginary, real}, each ACC_W bits in two's complement. Strobes outside a run have no effect.
- R5: After a run, each C element holds the full complex sum over all N inner terms of A row × B column: re = Σ(ar·br − ai·bi), im = Σ(ar·bi + ai·br).
- R6: The first inner tile of each output tile writes without reading, so earlier buffer contents are discarded. A one-tile size therefore writes each result directly.
- R7: Consecutive accepted results at the same buffer address accumulate correctly, with no lost update.
- R8: `done` is low in the cycle after the final result is accepted and high from the next cycle on (one cycle after the last write-back). It stays high until the next accepted start.
- R9: A `start` pulse during a run is ignored. It raises no request, and neither the size nor the result is changed.
- R10: `cData` shows element (`cRow`, `cCol`) one cycle after the address is applied, packed {im, re}. Each component is saturated to the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a product (idle only) |
| dimLog | input | DLW | log2 of matrix size in tiles |
| aReq | output | 1 | A tile read strobe |
| aRowTile | output | TW | A tile row index (i) |
| aColTile | output | TW | A tile column index (k) |
| bReq | output | 1 | B tile read strobe |
| bRowTile | output | TW | B tile row index (k) |
| bColTile | output | TW | B tile column index (j) |
| resValid | input | 1 | Engine result element valid |
| resData | input | 2·ACC_W | Partial product element {im, re} |
| done | output | 1 | Matrix complete |
| cRow | input | CW | Readout row |
| cCol | input | CW | Readout column |
| cData | output | 32 | Saturated C element {im, re} |

## Verification
The bench builds two instances, both with MAX_TILES = 4. One uses TILE = 4, so 4, 8 and 16 sizes with multi-element tiles, gapped streams, a busy-time start and a saturating data set can be swept and every C element compared. The other uses TILE = 1, where each tile is a single element and successive inner tiles strike the same address back to back. That makes the forwarding path and the out-of-range size clamp reachable in a few hundred cycles.

// File: rtl/gemm_acc_pkg.sv
package gemm_acc_pkg;

  function automatic int bitsFor(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_DRAIN} seqState_t;

  // Strobes from sequencer to accumulate datapath
  typedef struct packed {
    logic accValid;   // accept one result element this cycle
    logic accClear;   // first inner tile: ignore stored sum
    logic accLast;    // final element of the whole run
    logic clearDone;  // new run accepted
  } accCtl_t;

endpackage

// File: rtl/gemm_acc_ctrl.sv
module gemm_acc_ctrl
  import gemm_acc_pkg::*;
#(
  parameter int TILE = 32,
  parameter int MAX_TILES = 2,
  parameter int LOGS = 1,
  parameter int TW = 1,
  parameter int DLW = 1,
  parameter int AW = 12,
  parameter int EW = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [DLW-1:0] dimLog,
  input  logic           resValid,
  output logic           tileReq,
  output logic [TW-1:0]  rowTile,
  output logic [TW-1:0]  innerTile,
  output logic [TW-1:0]  colTile,
  output logic [AW-1:0]  accAddr,
  output accCtl_t        ctl,
  output logic           busy
);
  localparam int MAXDIM = TILE * MAX_TILES;
  localparam int EL = TILE * TILE;

  seqState_t st;
  logic [TW-1:0] iQ, jQ, kQ, nI, nJ, nK, lim;
  logic [EW-1:0] elemQ;
  logic [DLW-1:0] logQ, dimEff;
  logic accept, lastElem, tileDone, allDone, startGo;
  int rowIdx, colIdx;

  always_comb begin
    dimEff   = (dimLog > DLW'(LOGS)) ? DLW'(LOGS) : dimLog;
    lim      = TW'((32'd1 << logQ) - 32'd1);
    startGo  = (st == S_IDLE) && start;
    accept   = (st == S_COLLECT) && resValid;
    lastElem = (elemQ == EW'(EL - 1));
    tileDone = accept && lastElem;
    allDone  = tileDone && (kQ == lim) && (jQ == lim) && (iQ == lim);
    nI = iQ; nJ = jQ; nK = kQ + 1'b1;
    if (kQ == lim) begin
      nK = '0;
      if (jQ == lim) begin
        nJ = '0;
        nI = iQ + 1'b1;
      end else begin
        nJ = jQ + 1'b1;
      end
    end
    tileReq   = startGo || (tileDone && !allDone);
    rowTile   = startGo ? '0 : (tileDone ? nI : iQ);
    colTile   = startGo ? '0 : (tileDone ? nJ : jQ);
    innerTile = startGo ? '0 : (tileDone ? nK : kQ);
    rowIdx  = 32'(iQ) * TILE + 32'(elemQ) / TILE;
    colIdx  = 32'(jQ) * TILE + 32'(elemQ) % TILE;
    accAddr = AW'(rowIdx * MAXDIM + colIdx);
    ctl.accValid  = accept;
    ctl.accClear  = (kQ == '0);
    ctl.accLast   = allDone;
    ctl.clearDone = startGo;
    busy = (st != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE;
      iQ <= '0; jQ <= '0; kQ <= '0;
      elemQ <= '0;
      logQ <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_COLLECT;
          logQ <= dimEff;
          iQ <= '0; jQ <= '0; kQ <= '0;
          elemQ <= '0;
        end
        S_COLLECT: if (accept) begin
          elemQ <= lastElem ? '0 : elemQ + 1'b1;
          if (tileDone) begin
            iQ <= nI; jQ <= nJ; kQ <= nK;
          end
          if (allDone) st <= S_DRAIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gemm_acc_datapath.sv
module gemm_acc_datapath
  import gemm_acc_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16,
  parameter int DEPTH = 4096,
  parameter int AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  accCtl_t            ctl,
  input  logic [AW-1:0]      accAddr,
  input  logic [2*ACC_W-1:0] resData,
  input  logic               busy,
  input  logic [AW-1:0]      rdAddr,
  output logic [2*OUT_W-1:0] cData,
  output logic               done
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  logic [2*ACC_W-1:0] sumBuf [DEPTH];
  logic [2*ACC_W-1:0] rdQ, sumQ, res1, base, sum;
  logic [AW-1:0] addr1, rdSel;
  logic v1, clr1, last1, fwd1;

  function automatic logic [OUT_W-1:0] clampComp(input logic signed [ACC_W-1:0] x);
    if (x > SAT_HI) return SAT_HI[OUT_W-1:0];
    if (x < SAT_LO) return SAT_LO[OUT_W-1:0];
    return x[OUT_W-1:0];
  endfunction

  always_comb begin
    rdSel = busy ? accAddr : rdAddr;
    base  = clr1 ? '0 : (fwd1 ? sumQ : rdQ);
    sum[ACC_W-1:0]       = base[ACC_W-1:0] + res1[ACC_W-1:0];
    sum[2*ACC_W-1:ACC_W] = base[2*ACC_W-1:ACC_W] + res1[2*ACC_W-1:ACC_W];
    cData = {clampComp(rdQ[2*ACC_W-1:ACC_W]), clampComp(rdQ[ACC_W-1:0])};
  end

  always_ff @(posedge clk) begin
    rdQ <= sumBuf[rdSel];
    if (v1) begin
      sumBuf[addr1] <= sum;
      sumQ <= sum;
    end
    res1  <= resData;
    addr1 <= accAddr;
    clr1  <= ctl.accClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; last1 <= 1'b0; fwd1 <= 1'b0; done <= 1'b0;
    end else begin
      v1    <= ctl.accValid;
      last1 <= ctl.accValid && ctl.accLast;
      fwd1  <= ctl.accValid && v1 && (accAddr == addr1);
      if (ctl.clearDone) done <= 1'b0;
      else if (v1 && last1) done <= 1'b1;
    end
  end
endmodule

// File: rtl/gemm_tile_acc.sv
module gemm_tile_acc
  import gemm_acc_pkg::*;
#(
  parameter int TILE = 32,
  parameter int MAX_TILES = 2,
  parameter int ACC_W = 48,
  localparam int LOGS = $clog2(MAX_TILES),
  localparam int TW = bitsFor(MAX_TILES),
  localparam int DLW = bitsFor(LOGS + 1),
  localparam int MAXDIM = TILE * MAX_TILES,
  localparam int CW = bitsFor(MAXDIM),
  localparam int DEPTH = MAXDIM * MAXDIM,
  localparam int AW = bitsFor(DEPTH),
  localparam int EW = bitsFor(TILE * TILE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DLW-1:0]     dimLog,
  output logic               aReq,
  output logic [TW-1:0]      aRowTile,
  output logic [TW-1:0]      aColTile,
  output logic               bReq,
  output logic [TW-1:0]      bRowTile,
  output logic [TW-1:0]      bColTile,
  input  logic               resValid,
  input  logic [2*ACC_W-1:0] resData,
  output logic               done,
  input  logic [CW-1:0]      cRow,
  input  logic [CW-1:0]      cCol,
  output logic [31:0]        cData
);
  accCtl_t ctl;
  logic tileReq, busy;
  logic [TW-1:0] rowTile, innerTile, colTile;
  logic [AW-1:0] accAddr, rdAddr;

  assign rdAddr   = AW'(32'(cRow) * MAXDIM + 32'(cCol));
  assign aReq     = tileReq;
  assign bReq     = tileReq;
  assign aRowTile = rowTile;
  assign aColTile = innerTile;
  assign bRowTile = innerTile;
  assign bColTile = colTile;

  gemm_acc_ctrl #(
    .TILE(TILE), .MAX_TILES(MAX_TILES), .LOGS(LOGS), .TW(TW),
    .DLW(DLW), .AW(AW), .EW(EW)
  ) seq (
    .clk(clk), .rstN(rstN), .start(start), .dimLog(dimLog),
    .resValid(resValid), .tileReq(tileReq), .rowTile(rowTile),
    .innerTile(innerTile), .colTile(colTile), .accAddr(accAddr),
    .ctl(ctl), .busy(busy)
  );

  gemm_acc_datapath #(
    .ACC_W(ACC_W), .OUT_W(16), .DEPTH(DEPTH), .AW(AW)
  ) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accAddr(accAddr),
    .resData(resData), .busy(busy), .rdAddr(rdAddr),
    .cData(cData), .done(done)
  );
endmodule

// File: rtl/gemm_tile_acc_chk.sv
module gemm_tile_acc_chk #(
  parameter int TW = 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          resValid,
  input logic          aReq,
  input logic [TW-1:0] aRowTile,
  input logic [TW-1:0] aColTile,
  input logic [TW-1:0] bColTile,
  input logic          busy,
  input logic          done
);
  AST_START_ZERO_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && !busy) |-> (aRowTile == '0 && aColTile == '0 && bColTile == '0)); // R2

  AST_REQ_STARTS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    aReq |=> busy); // R3

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !resValid) |-> !aReq); // R9

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy)); // R8

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
endmodule

bind gemm_tile_acc gemm_tile_acc_chk #(.TW(TW)) chk (
  .clk(clk), .rstN(rstN), .start(start), .resValid(resValid),
  .aReq(aReq), .aRowTile(aRowTile), .aColTile(aColTile),
  .bColTile(bColTile), .busy(busy), .done(done)
);

// File: tb/gemm_tile_acc_test.sv
`timescale 1ns/1ps
module gemm_tile_acc_test;
  localparam int MT = 4;
  localparam int AWD = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] dimLog = '0;
  logic resValid = 1'b0;
  logic [2*AWD-1:0] resData = '0;
  logic [3:0] cRow = '0, cCol = '0;
  logic sel = 1'b0;

  logic aReq0, bReq0, done0, aReq1, bReq1, done1;
  logic [1:0] aRow0, aCol0, bRow0, bCol0, aRow1, aCol1, bRow1, bCol1;
  logic [31:0] cData0, cData1;

  int compared = 0, mismatched = 0, tSz = 4;
  int aRe[16][16], aIm[16][16], bRe[16][16], bIm[16][16];

  always #2 clk = ~clk;

  gemm_tile_acc #(.TILE(4), .MAX_TILES(MT), .ACC_W(AWD)) uut (
    .clk(clk), .rstN(rstN), .start(start && !sel), .dimLog(dimLog),
    .aReq(aReq0), .aRowTile(aRow0), .aColTile(aCol0),
    .bReq(bReq0), .bRowTile(bRow0), .bColTile(bCol0),
    .resValid(resValid && !sel), .resData(resData), .done(done0),
    .cRow(cRow), .cCol(cCol), .cData(cData0)
  );

  gemm_tile_acc #(.TILE(1), .MAX_TILES(MT), .ACC_W(AWD)) uutNarrow (
    .clk(clk), .rstN(rstN), .start(start && sel), .dimLog(dimLog),
    .aReq(aReq1), .aRowTile(aRow1), .aColTile(aCol1),
    .bReq(bReq1), .bRowTile(bRow1), .bColTile(bCol1),
    .resValid(resValid && sel), .resData(resData), .done(done1),
    .cRow(cRow[1:0]), .cCol(cCol[1:0]), .cData(cData1)
  );

  wire aReqM = sel ? aReq1 : aReq0;
  wire bReqM = sel ? bReq1 : bReq0;
  wire [1:0] aRowM = sel ? aRow1 : aRow0;
  wire [1:0] aColM = sel ? aCol1 : aCol0;
  wire [1:0] bRowM = sel ? bRow1 : bRow0;
  wire [1:0] bColM = sel ? bCol1 : bCol0;
  wire doneM = sel ? done1 : done0;
  wire [31:0] cDataM = sel ? cData1 : cData0;

  task automatic chk(input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [15:0] sat16(input longint v);
    if (v > 32767) return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [2*AWD-1:0] partial(input int i, j, k, e);
    longint re = 0, im = 0;
    int r = i * tSz + e / tSz;
    int c = j * tSz + e % tSz;
    for (int x = k * tSz; x < (k + 1) * tSz; x++) begin
      re += longint'(aRe[r][x]) * bRe[x][c] - longint'(aIm[r][x]) * bIm[x][c];
      im += longint'(aRe[r][x]) * bIm[x][c] + longint'(aIm[r][x]) * bRe[x][c];
    end
    return {AWD'(im), AWD'(re)};
  endfunction

  function automatic logic [31:0] expC(input int r, c, n);
    longint re = 0, im = 0;
    for (int x = 0; x < n; x++) begin
      re += longint'(aRe[r][x]) * bRe[x][c] - longint'(aIm[r][x]) * bIm[x][c];
      im += longint'(aRe[r][x]) * bIm[x][c] + longint'(aIm[r][x]) * bRe[x][c];
    end
    return {sat16(im), sat16(re)};
  endfunction

  task automatic fill(input int seed, input bit big);
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) begin
        aRe[r][c] = big ? 30000 : ((r * 3 + c * 5 + seed) % 15) - 7;
        aIm[r][c] = big ? -30000 : ((r * 7 + c * 2 + seed * 3) % 13) - 6;
        bRe[r][c] = big ? 30000 : ((r * 5 + c * 11 + seed) % 17) - 8;
        bIm[r][c] = big ? 0 : ((r + c * 3 + seed * 5) % 9) - 4;
      end
    end
  endtask

  task automatic runGemm(input int dl, input int nT, input bit gaps, input bit poke);
    int ei = 0, ej = 0, ek = 0;
    int total = nT * nT * nT;
    int el = tSz * tSz;
    @(negedge clk);
    dimLog = 2'(dl);
    start = 1'b1;
    #1;
    chk("R2 request at start", aReqM, 1);
    chk("R2 B strobe at start", bReqM, 1);
    chk("R2 start indices", {aRowM, aColM, bRowM, bColM}, 0);
    for (int t = 0; t < total; t++) begin
      for (int e = 0; e < el; e++) begin
        @(negedge clk);
        start = 1'b0;
        resValid = 1'b0;
        if (gaps && (e % 3 == 1)) @(negedge clk);
        if (poke && t == 0 && e == 1) begin
          start = 1'b1;
          dimLog = 2'd0;
        end
        resValid = 1'b1;
        resData = partial(ei, ej, ek, e);
        #1;
        if (poke && t == 0 && e == 1) chk("R9 start while busy gives no request", aReqM, 0);
        if (e == el - 1) begin
          ek++;
          if (ek == nT) begin
            ek = 0; ej++;
            if (ej == nT) begin ej = 0; ei++; end
          end
          if (t < total - 1) begin
            chk("R3 next request", aReqM, 1);
            chk("R3 A row tile", aRowM, ei);
            chk("R3 A inner tile", aColM, ek);
            chk("R3 B inner tile", bRowM, ek);
            chk("R3 B column tile", bColM, ej);
          end else begin
            chk("R3 no request after final tile", aReqM, 0);
          end
        end
      end
    end
    @(negedge clk);
    resValid = 1'b0;
    start = 1'b0;
    chk("R8 done low right after final accept", doneM, 0);
    @(negedge clk);
    chk("R8 done high after write-back", doneM, 1);
  endtask

  task automatic checkC(input string what, input int n);
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < n; c++) begin
        @(negedge clk);
        cRow = 4'(r);
        cCol = 4'(c);
        @(negedge clk);
        chk(what, cDataM, expC(r, c, n));
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8 done low after reset", done0, 0);
    chk("R2 no request after reset", aReq0, 0);
    chk("R8 done low after reset narrow", done1, 0);
    chk("R2 no request after reset narrow", aReq1, 0);

    // Wide tiles: 16x16 with gaps and a busy-time start (R5, R9, R4 ordering)
    sel = 1'b0; tSz = 4;
    fill(1, 1'b0);
    runGemm(2, 4, 1'b1, 1'b1);
    checkC("R5 R10 16x16 product", 16);

    // Single tile over stale contents (R6)
    fill(2, 1'b0);
    runGemm(0, 1, 1'b1, 1'b0);
    checkC("R6 4x4 direct write", 4);

    // Saturation on readout (R10), 8x8 accumulation
    fill(3, 1'b1);
    runGemm(1, 2, 1'b0, 1'b0);
    checkC("R10 saturated readout", 8);

    // Strobes while idle are ignored (R4), done persists (R8)
    repeat (3) begin
      @(negedge clk);
      resValid = 1'b1;
      resData = {2{48'h0000_1234_5678}};
    end
    @(negedge clk);
    resValid = 1'b0;
    chk("R8 done holds while idle", doneM, 1);
    checkC("R4 idle strobes ignored", 8);

    // One-element tiles: same address on successive cycles (R7), size clamp (R1)
    sel = 1'b1; tSz = 1;
    fill(4, 1'b0);
    runGemm(3, 4, 1'b0, 1'b0);
    checkC("R7 R1 forwarded accumulation", 4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule